// File: doc/BRIEF.md
# Pointer-Linked Tag Directory

This block is a tag directory that lives apart from the data banks it describes. Every tag entry in a set-associative array holds a valid flag, the address tag, and a forward pointer. The forward pointer names the bank and the frame inside that bank where the block's data sits. Each data frame keeps an occupancy flag and a reverse pointer, which names the set and way of the tag entry that owns the frame. Because of these pointers, a block's data can sit in any frame of any bank, whatever its set index. A lookup hit hands back the exact bank and frame, so no bank has to be searched.

The directory accepts one request at a time on a single command port. Lookup, allocation, invalidation and probe each finish in one cycle. An allocation takes the lowest free way of the addressed set and the lowest free frame of the bank the requester chooses. An invalidation releases the frame that its forward pointer names. A move relocates a block from one frame to another. The move uses the source frame's reverse pointer to find the owning tag entry, then rewrites that entry's forward pointer. A probe reads a frame's reverse pointer back out, so the two-way linkage can be checked from outside the block.

Top module: `fwd_tag_store`

## Requirements
- R1: After reset every tag entry is invalid and every frame is free: lookups miss, probes report unoccupied, `req_ready` is high and `rsp_valid` is low.
- R2: A lookup (op code 0) is answered with `rsp_valid` one cycle after it is accepted. On a hit, `rsp_ok`=1 and the response carries the request's set, the matching way and the entry's forward bank and frame.
- R3: A lookup whose tag matches no valid way of its set answers `rsp_ok`=0.
- R4: An allocation (op code 1) takes the lowest-numbered invalid way of the set and the lowest-numbered free frame of `req_bank`. The frame choice does not depend on the set. The response returns the set, way, bank and frame, and the frame's reverse pointer is set to that set and way.
- R5: An allocation fails (`rsp_ok`=0) and changes no state when any of these holds: the tag is already valid in the set, the set has no invalid way, or the chosen bank has no free frame.
- R6: A probe (op code 4) of a bank and frame answers in one cycle. It returns `rsp_ok` equal to the frame's occupancy, the reverse-pointer set and way, and echoes the bank and frame. For every valid entry, probing its forward pointer returns that entry's own set and way.
- R7: An invalidation (op code 2) that hits clears the entry, frees the frame its forward pointer names, and returns the freed location with `rsp_ok`=1. An invalidation that misses answers `rsp_ok`=0 and changes nothing.
- R8: A move (op code 3) with an occupied source frame (`req_bank`/`req_frame`) and a free destination frame (`req_dst_bank`/`req_dst_frame`) takes two cycles. `req_ready` is low in the second cycle. `rsp_valid` with `rsp_ok`=1 comes two cycles after acceptance and returns the owning set, way and the destination. Afterwards the owner's forward pointer names the destination, the destination's reverse pointer names the owner, and the source frame is free.
- R9: A move whose source frame is free or whose destination frame is occupied answers one cycle after acceptance with `rsp_ok`=0 and changes nothing.
- R10: Op codes 5 to 7 answer one cycle after acceptance with `rsp_ok`=0 and change nothing.
- R11: Every response with `rsp_ok`=0 drives `rsp_set`, `rsp_way`, `rsp_bank` and `rsp_frame` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 lookup, 1 allocate, 2 invalidate, 3 move, 4 probe) |
| req_tag | input | TAG_W | Address tag |
| req_set | input | SET_W | Set index |
| req_bank | input | BANK_W | Target bank (allocate), source bank (move), probed bank |
| req_frame | input | FRAME_W | Source frame (move), probed frame |
| req_dst_bank | input | BANK_W | Destination bank of a move |
| req_dst_frame | input | FRAME_W | Destination frame of a move |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Hit / success / occupied |
| rsp_set | output | SET_W | Set of the entry concerned |
| rsp_way | output | WAY_W | Way of the entry concerned |
| rsp_bank | output | BANK_W | Bank of the data frame |
| rsp_frame | output | FRAME_W | Frame within the bank |

## Verification
Lookups, allocations, invalidations, probes, rejected moves and unknown op codes must answer on the first falling clock edge after the rising edge that accepts them. The bench drops `req_valid` and compares the whole response at that edge. A successful move must show `rsp_valid` low and `req_ready` low at that same falling edge, and its response is compared one full cycle later. A reference model in the bench predicts in advance which of the two timings applies. After every operation that may change state, a sweep probes every frame and looks up every live entry. It then probes the returned forward pointer to confirm that the reverse pointer leads back to the same set and way.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_INVAL  = 3'd2,
    OP_MOVE   = 3'd3,
    OP_PROBE  = 3'd4
  } ftp_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_MOVE2 = 1'b1
  } ftp_state_e;

  // Highest op code that has a defined meaning.
  localparam logic [2:0] OP_LAST = 3'd4;

  function automatic logic op_known(input logic [2:0] op);
    return op <= OP_LAST;
  endfunction
endpackage

// File: rtl/ftp_tag_array.sv
module ftp_tag_array #(
  parameter int SETS    = 4,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 6,
  parameter int SET_W   = 2,
  parameter int WAY_W   = 2,
  parameter int BANK_W  = 1,
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SET_W-1:0]   lk_set,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [WAY_W-1:0]   lk_way,
  output logic [BANK_W-1:0]  lk_bank,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               fw_found,
  output logic [WAY_W-1:0]   fw_way,
  input  logic               wr_en,
  input  logic [SET_W-1:0]   wr_set,
  input  logic [WAY_W-1:0]   wr_way,
  input  logic               wr_valid,
  input  logic               wr_tag_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [FRAME_W-1:0] wr_frame
);
  logic               ent_v [SETS][WAYS];
  logic [TAG_W-1:0]   ent_t [SETS][WAYS];
  logic [BANK_W-1:0]  ent_b [SETS][WAYS];
  logic [FRAME_W-1:0] ent_f [SETS][WAYS];

  // Tag compare across the ways of one set; the first match wins.
  always_comb begin
    lk_hit   = 1'b0;
    lk_way   = '0;
    lk_bank  = '0;
    lk_frame = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lk_hit && ent_v[lk_set][w] && ent_t[lk_set][w] == lk_tag) begin
        lk_hit   = 1'b1;
        lk_way   = WAY_W'(w);
        lk_bank  = ent_b[lk_set][w];
        lk_frame = ent_f[lk_set][w];
      end
    end
  end

  // Lowest invalid way of the set.
  always_comb begin
    fw_found = 1'b0;
    fw_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!fw_found && !ent_v[lk_set][w]) begin
        fw_found = 1'b1;
        fw_way   = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          ent_v[s][w] <= 1'b0;
          ent_t[s][w] <= '0;
          ent_b[s][w] <= '0;
          ent_f[s][w] <= '0;
        end
      end
    end else if (wr_en) begin
      ent_v[wr_set][wr_way] <= wr_valid;
      if (wr_tag_en) ent_t[wr_set][wr_way] <= wr_tag;
      ent_b[wr_set][wr_way] <= wr_bank;
      ent_f[wr_set][wr_way] <= wr_frame;
    end
  end
endmodule

// File: rtl/ftp_frame_table.sv
module ftp_frame_table #(
  parameter int BANKS   = 2,
  parameter int FRAMES  = 8,
  parameter int SET_W   = 2,
  parameter int WAY_W   = 2,
  parameter int BANK_W  = 1,
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BANK_W-1:0]  a_bank,
  input  logic [FRAME_W-1:0] a_frame,
  output logic               a_occ,
  output logic [SET_W-1:0]   a_set,
  output logic [WAY_W-1:0]   a_way,
  input  logic [BANK_W-1:0]  b_bank,
  input  logic [FRAME_W-1:0] b_frame,
  output logic               b_occ,
  input  logic [BANK_W-1:0]  al_bank,
  output logic               al_found,
  output logic [FRAME_W-1:0] al_frame,
  input  logic               set_en,
  input  logic [BANK_W-1:0]  set_bank,
  input  logic [FRAME_W-1:0] set_frame,
  input  logic [SET_W-1:0]   set_rset,
  input  logic [WAY_W-1:0]   set_rway,
  input  logic               clr_en,
  input  logic [BANK_W-1:0]  clr_bank,
  input  logic [FRAME_W-1:0] clr_frame
);
  logic [FRAMES-1:0]        occ   [BANKS];
  logic [SET_W-1:0]         rev_s [BANKS][FRAMES];
  logic [WAY_W-1:0]         rev_w [BANKS][FRAMES];
  logic [BANKS-1:0]         bk_found;
  logic [BANKS*FRAME_W-1:0] bk_idx;

  // One lowest-free-frame picker per bank.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic               fnd;
    logic [FRAME_W-1:0] idx;
    always_comb begin
      fnd = 1'b0;
      idx = '0;
      for (int f = 0; f < FRAMES; f++) begin
        if (!fnd && !occ[b][f]) begin
          fnd = 1'b1;
          idx = FRAME_W'(f);
        end
      end
    end
    assign bk_found[b]                   = fnd;
    assign bk_idx[b*FRAME_W +: FRAME_W] = idx;
  end

  assign al_found = bk_found[al_bank];
  assign al_frame = bk_idx[al_bank*FRAME_W +: FRAME_W];

  assign a_occ = occ[a_bank][a_frame];
  assign a_set = rev_s[a_bank][a_frame];
  assign a_way = rev_w[a_bank][a_frame];
  assign b_occ = occ[b_bank][b_frame];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        occ[b] <= '0;
        for (int f = 0; f < FRAMES; f++) begin
          rev_s[b][f] <= '0;
          rev_w[b][f] <= '0;
        end
      end
    end else begin
      if (clr_en) occ[clr_bank][clr_frame] <= 1'b0;
      if (set_en) begin
        occ[set_bank][set_frame]   <= 1'b1;
        rev_s[set_bank][set_frame] <= set_rset;
        rev_w[set_bank][set_frame] <= set_rway;
      end
    end
  end
endmodule

// File: rtl/fwd_tag_store.sv
module fwd_tag_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int BANKS  = 2,
  parameter int FRAMES = 8,
  parameter int TAG_W  = 6,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int BANK_W  = $clog2(BANKS),
  localparam int FRAME_W = $clog2(FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [SET_W-1:0]   req_set,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic [BANK_W-1:0]  req_dst_bank,
  input  logic [FRAME_W-1:0] req_dst_frame,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [SET_W-1:0]   rsp_set,
  output logic [WAY_W-1:0]   rsp_way,
  output logic [BANK_W-1:0]  rsp_bank,
  output logic [FRAME_W-1:0] rsp_frame
);
  import ftp_pkg::*;

  ftp_state_e state;

  // Named internal events, observed by the bound checker.
  logic acc, ev_alloc, ev_inval, ev_move_start, ev_move_commit;

  logic               lk_hit, fw_found;
  logic [WAY_W-1:0]   lk_way, fw_way;
  logic [BANK_W-1:0]  lk_bank;
  logic [FRAME_W-1:0] lk_frame;
  logic               a_occ, b_occ, fr_found;
  logic [SET_W-1:0]   a_set;
  logic [WAY_W-1:0]   a_way;
  logic [FRAME_W-1:0] fr_frame;

  logic [SET_W-1:0]   mv_set;
  logic [WAY_W-1:0]   mv_way;
  logic [BANK_W-1:0]  mv_sbank, mv_dbank;
  logic [FRAME_W-1:0] mv_sframe, mv_dframe;

  logic               tw_en, tw_valid, tw_tag_en;
  logic [SET_W-1:0]   tw_set;
  logic [WAY_W-1:0]   tw_way;
  logic [BANK_W-1:0]  tw_bank;
  logic [FRAME_W-1:0] tw_frame;

  logic               fs_en, fc_en;
  logic [BANK_W-1:0]  fs_bank, fc_bank;
  logic [FRAME_W-1:0] fs_frame, fc_frame;
  logic [SET_W-1:0]   fs_set;
  logic [WAY_W-1:0]   fs_way;

  logic               nx_ok;
  logic [SET_W-1:0]   nx_set;
  logic [WAY_W-1:0]   nx_way;
  logic [BANK_W-1:0]  nx_bank;
  logic [FRAME_W-1:0] nx_frame;

  ftp_tag_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W),
    .WAY_W(WAY_W), .BANK_W(BANK_W), .FRAME_W(FRAME_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(req_set), .lk_tag(req_tag),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_bank(lk_bank), .lk_frame(lk_frame),
    .fw_found(fw_found), .fw_way(fw_way),
    .wr_en(tw_en), .wr_set(tw_set), .wr_way(tw_way), .wr_valid(tw_valid),
    .wr_tag_en(tw_tag_en), .wr_tag(req_tag), .wr_bank(tw_bank), .wr_frame(tw_frame)
  );

  ftp_frame_table #(
    .BANKS(BANKS), .FRAMES(FRAMES), .SET_W(SET_W), .WAY_W(WAY_W),
    .BANK_W(BANK_W), .FRAME_W(FRAME_W)
  ) u_frames (
    .clk(clk), .rst_n(rst_n),
    .a_bank(req_bank), .a_frame(req_frame),
    .a_occ(a_occ), .a_set(a_set), .a_way(a_way),
    .b_bank(req_dst_bank), .b_frame(req_dst_frame), .b_occ(b_occ),
    .al_bank(req_bank), .al_found(fr_found), .al_frame(fr_frame),
    .set_en(fs_en), .set_bank(fs_bank), .set_frame(fs_frame),
    .set_rset(fs_set), .set_rway(fs_way),
    .clr_en(fc_en), .clr_bank(fc_bank), .clr_frame(fc_frame)
  );

  assign req_ready      = (state == ST_IDLE);
  assign acc            = req_valid && req_ready;
  assign ev_alloc       = acc && req_op == OP_ALLOC && !lk_hit && fw_found && fr_found;
  assign ev_inval       = acc && req_op == OP_INVAL && lk_hit;
  assign ev_move_start  = acc && req_op == OP_MOVE && a_occ && !b_occ;
  assign ev_move_commit = (state == ST_MOVE2);

  // Tag-entry write port: commit of a move, allocation or invalidation.
  always_comb begin
    tw_en     = 1'b0;
    tw_valid  = 1'b0;
    tw_tag_en = 1'b0;
    tw_set    = req_set;
    tw_way    = lk_way;
    tw_bank   = lk_bank;
    tw_frame  = lk_frame;
    if (ev_move_commit) begin
      tw_en    = 1'b1;
      tw_valid = 1'b1;
      tw_set   = mv_set;
      tw_way   = mv_way;
      tw_bank  = mv_dbank;
      tw_frame = mv_dframe;
    end else if (ev_alloc) begin
      tw_en     = 1'b1;
      tw_valid  = 1'b1;
      tw_tag_en = 1'b1;
      tw_way    = fw_way;
      tw_bank   = req_bank;
      tw_frame  = fr_frame;
    end else if (ev_inval) begin
      tw_en = 1'b1;
    end
  end

  // Frame-table set and clear ports.
  always_comb begin
    fs_en    = ev_move_commit || ev_alloc;
    fs_bank  = ev_move_commit ? mv_dbank  : req_bank;
    fs_frame = ev_move_commit ? mv_dframe : fr_frame;
    fs_set   = ev_move_commit ? mv_set    : req_set;
    fs_way   = ev_move_commit ? mv_way    : fw_way;
    fc_en    = ev_move_commit || ev_inval;
    fc_bank  = ev_move_commit ? mv_sbank  : lk_bank;
    fc_frame = ev_move_commit ? mv_sframe : lk_frame;
  end

  // Single-cycle response contents; a failure clears every field.
  always_comb begin
    nx_ok    = 1'b0;
    nx_set   = req_set;
    nx_way   = lk_way;
    nx_bank  = lk_bank;
    nx_frame = lk_frame;
    if (op_known(req_op)) begin
      case (req_op)
        OP_LOOKUP, OP_INVAL: nx_ok = lk_hit;
        OP_ALLOC: begin
          nx_ok    = ev_alloc;
          nx_way   = fw_way;
          nx_bank  = req_bank;
          nx_frame = fr_frame;
        end
        OP_PROBE: begin
          nx_ok    = a_occ;
          nx_set   = a_set;
          nx_way   = a_way;
          nx_bank  = req_bank;
          nx_frame = req_frame;
        end
        default: nx_ok = 1'b0;
      endcase
    end
    if (!nx_ok) begin
      nx_set   = '0;
      nx_way   = '0;
      nx_bank  = '0;
      nx_frame = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_set   <= '0;
      rsp_way   <= '0;
      rsp_bank  <= '0;
      rsp_frame <= '0;
      mv_set    <= '0;
      mv_way    <= '0;
      mv_sbank  <= '0;
      mv_sframe <= '0;
      mv_dbank  <= '0;
      mv_dframe <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (ev_move_commit) begin
        state     <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_ok    <= 1'b1;
        rsp_set   <= mv_set;
        rsp_way   <= mv_way;
        rsp_bank  <= mv_dbank;
        rsp_frame <= mv_dframe;
      end else if (ev_move_start) begin
        state     <= ST_MOVE2;
        mv_set    <= a_set;
        mv_way    <= a_way;
        mv_sbank  <= req_bank;
        mv_sframe <= req_frame;
        mv_dbank  <= req_dst_bank;
        mv_dframe <= req_dst_frame;
      end else if (acc) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= nx_ok;
        rsp_set   <= nx_set;
        rsp_way   <= nx_way;
        rsp_bank  <= nx_bank;
        rsp_frame <= nx_frame;
      end
    end
  end
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int SET_W   = 2,
  parameter int WAY_W   = 2,
  parameter int BANK_W  = 1,
  parameter int FRAME_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         req_op,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ok,
  input logic [SET_W-1:0]   rsp_set,
  input logic [WAY_W-1:0]   rsp_way,
  input logic [BANK_W-1:0]  rsp_bank,
  input logic [FRAME_W-1:0] rsp_frame,
  input logic               acc,
  input logic               ev_alloc,
  input logic               ev_move_start,
  input logic               ev_move_commit,
  input logic               fr_found
);
  import ftp_pkg::*;

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> req_ready && !rsp_valid);

  p_lookup_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_LOOKUP |=> rsp_valid);

  p_alloc_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> rsp_valid && rsp_ok);

  p_full_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_ALLOC && !fr_found |=> rsp_valid && !rsp_ok);

  p_move_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_move_start |=> !req_ready && !rsp_valid && ev_move_commit);

  p_move_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_move_commit |=> rsp_valid && rsp_ok && req_ready);

  p_move_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_MOVE && !ev_move_start |=> rsp_valid && !rsp_ok);

  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op > OP_LAST |=> rsp_valid && !rsp_ok);

  p_fail_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> rsp_set == '0 && rsp_way == '0 && rsp_bank == '0 && rsp_frame == '0);

  p_rsp_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc) || $past(ev_move_commit));
endmodule

bind fwd_tag_store ftp_checker #(
  .SET_W(SET_W), .WAY_W(WAY_W), .BANK_W(BANK_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_set(rsp_set), .rsp_way(rsp_way),
  .rsp_bank(rsp_bank), .rsp_frame(rsp_frame), .acc(acc), .ev_alloc(ev_alloc),
  .ev_move_start(ev_move_start), .ev_move_commit(ev_move_commit), .fr_found(fr_found)
);

// File: tb/sim_fwd_tag_store.sv
module sim_fwd_tag_store;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, NW = 4, NB = 2, NF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [5:0] req_tag = '0;
  logic [1:0] req_set = '0;
  logic       req_bank = '0;
  logic [2:0] req_frame = '0;
  logic       req_dst_bank = '0;
  logic [2:0] req_dst_frame = '0;
  logic       req_ready, rsp_valid, rsp_ok;
  logic [1:0] rsp_set, rsp_way;
  logic       rsp_bank;
  logic [2:0] rsp_frame;

  int n_chk = 0, n_bad = 0;

  // Reference model
  bit m_v [NS][NW];
  int m_tag [NS][NW];
  int m_bk [NS][NW];
  int m_fr [NS][NW];
  bit f_occ [NB][NF];
  int f_s [NB][NF];
  int f_w [NB][NF];

  int g_bank, g_frame;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_tag_store #(.SETS(NS), .WAYS(NW), .BANKS(NB), .FRAMES(NF), .TAG_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_tag(req_tag), .req_set(req_set), .req_bank(req_bank), .req_frame(req_frame),
    .req_dst_bank(req_dst_bank), .req_dst_frame(req_dst_frame), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_set(rsp_set), .rsp_way(rsp_way),
    .rsp_bank(rsp_bank), .rsp_frame(rsp_frame)
  );

  task automatic chk(input bit good, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int pack_rsp(int ok, int s, int w, int b, int f);
    return ok * 10000 + s * 1000 + w * 100 + b * 10 + f;
  endfunction

  task automatic do_op(input int op, input int tag, input int set, input int bank,
                       input int frame, input int dbank, input int dframe, input string rq);
    int e_ok, e_s, e_w, e_b, e_f, hw, fw, ff;
    bit two;
    e_ok = 0; e_s = 0; e_w = 0; e_b = 0; e_f = 0; two = 0;
    hw = -1;
    for (int w = NW - 1; w >= 0; w--) if (m_v[set][w] && m_tag[set][w] == tag) hw = w;
    fw = -1;
    for (int w = NW - 1; w >= 0; w--) if (!m_v[set][w]) fw = w;
    ff = -1;
    for (int f = NF - 1; f >= 0; f--) if (!f_occ[bank][f]) ff = f;
    case (op)
      0, 2: if (hw >= 0) begin
        e_ok = 1; e_s = set; e_w = hw; e_b = m_bk[set][hw]; e_f = m_fr[set][hw];
      end
      1: if (hw < 0 && fw >= 0 && ff >= 0) begin
        e_ok = 1; e_s = set; e_w = fw; e_b = bank; e_f = ff;
      end
      3: if (f_occ[bank][frame] && !f_occ[dbank][dframe]) begin
        two = 1; e_ok = 1; e_s = f_s[bank][frame]; e_w = f_w[bank][frame];
        e_b = dbank; e_f = dframe;
      end
      4: if (f_occ[bank][frame]) begin
        e_ok = 1; e_s = f_s[bank][frame]; e_w = f_w[bank][frame]; e_b = bank; e_f = frame;
      end
      default: e_ok = 0;
    endcase

    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_tag = 6'(tag); req_set = 2'(set);
    req_bank = 1'(bank); req_frame = 3'(frame); req_dst_bank = 1'(dbank);
    req_dst_frame = 3'(dframe);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (two) begin
      chk(!rsp_valid && !req_ready, rq, "move stall (valid,ready)",
          int'(rsp_valid) * 10 + int'(req_ready), 0);
      @(posedge clk);
      @(negedge clk);
    end
    chk(rsp_valid === 1'b1, rq, "rsp_valid", int'(rsp_valid), 1);
    chk(pack_rsp(int'(rsp_ok), int'(rsp_set), int'(rsp_way), int'(rsp_bank), int'(rsp_frame))
          == pack_rsp(e_ok, e_s, e_w, e_b, e_f), rq, "response ok/set/way/bank/frame",
        pack_rsp(int'(rsp_ok), int'(rsp_set), int'(rsp_way), int'(rsp_bank), int'(rsp_frame)),
        pack_rsp(e_ok, e_s, e_w, e_b, e_f));
    g_bank = int'(rsp_bank); g_frame = int'(rsp_frame);

    if (e_ok) begin
      case (op)
        1: begin
          m_v[set][fw] = 1; m_tag[set][fw] = tag; m_bk[set][fw] = bank; m_fr[set][fw] = ff;
          f_occ[bank][ff] = 1; f_s[bank][ff] = set; f_w[bank][ff] = fw;
        end
        2: begin
          m_v[set][hw] = 0; f_occ[e_b][e_f] = 0;
        end
        3: begin
          m_bk[e_s][e_w] = dbank; m_fr[e_s][e_w] = dframe;
          f_occ[bank][frame] = 0;
          f_occ[dbank][dframe] = 1; f_s[dbank][dframe] = e_s; f_w[dbank][dframe] = e_w;
        end
        default: ;
      endcase
    end
  endtask

  // Probe every frame, then follow each live entry's forward pointer back.
  task automatic sweep(input string rq);
    for (int b = 0; b < NB; b++)
      for (int f = 0; f < NF; f++)
        do_op(4, 0, 0, b, f, 0, 0, rq);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        if (m_v[s][w]) begin
          do_op(0, m_tag[s][w], s, 0, 0, 0, 0, "R2");
          do_op(4, 0, 0, g_bank, g_frame, 0, 0, "R6");
          chk(int'(rsp_set) == s && int'(rsp_way) == w, "R6", "reverse pointer set*10+way",
              int'(rsp_set) * 10 + int'(rsp_way), s * 10 + w);
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit [31:0] seed;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_v[s][w] = 0; m_tag[s][w] = 0; m_bk[s][w] = 0; m_fr[s][w] = 0;
      end
    for (int b = 0; b < NB; b++)
      for (int f = 0; f < NF; f++) begin
        f_occ[b][f] = 0; f_s[b][f] = 0; f_w[b][f] = 0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs and an empty directory
    chk(req_ready && !rsp_valid, "R1", "ready*10+valid after reset",
        int'(req_ready) * 10 + int'(rsp_valid), 10);
    do_op(0, 5, 1, 0, 0, 0, 0, "R1");
    sweep("R1");

    // R4: fill set 0 into bank 0, ways and frames in ascending order
    for (int i = 0; i < 4; i++) do_op(1, 10 + i, 0, 0, 0, 0, 0, "R4");
    // R5: set full, duplicate tag
    do_op(1, 20, 0, 1, 0, 0, 0, "R5");
    do_op(1, 3, 1, 0, 0, 0, 0, "R4");
    do_op(1, 3, 1, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) do_op(1, 30 + i, 2, 0, 0, 0, 0, "R4");
    // R5: bank 0 now full
    do_op(1, 40, 3, 0, 0, 0, 0, "R5");
    // R4: same set, other bank, frame independent of set
    do_op(1, 40, 3, 1, 0, 0, 0, "R4");
    sweep("R4");
    // R2 / R3
    do_op(0, 12, 0, 0, 0, 0, 0, "R2");
    do_op(0, 12, 1, 0, 0, 0, 0, "R3");
    do_op(0, 63, 2, 0, 0, 0, 0, "R3");
    // R8: move bank0 frame2 -> bank1 frame5
    do_op(3, 0, 0, 0, 2, 1, 5, "R8");
    sweep("R8");
    // R9: free source, occupied destination
    do_op(3, 0, 0, 0, 2, 1, 6, "R9");
    do_op(3, 0, 0, 0, 3, 1, 0, "R9");
    sweep("R9");
    // R7: hit and miss
    do_op(2, 30, 2, 0, 0, 0, 0, "R7");
    do_op(2, 30, 2, 0, 0, 0, 0, "R7");
    sweep("R7");
    do_op(1, 50, 2, 0, 0, 0, 0, "R4");
    // R10: undefined codes
    for (int c = 5; c < 8; c++) do_op(c, 12, 0, 0, 1, 1, 7, "R10");
    sweep("R10");
    // R11 plus all others: pseudo-random mix against the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 150; i++) begin
      int op;
      seed = seed * 32'd1103515245 + 32'd12345;
      op = int'(seed[30:28]);
      if (op > 5) op = 1;
      do_op(op, int'(seed[5:3]), int'(seed[7:6]), int'(seed[8]), int'(seed[11:9]),
            int'(seed[12]), int'(seed[15:13]), "R11");
      if (op == 1 || op == 2 || op == 3) sweep("R6");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule